// File: doc/BRIEF.md
# Debounced Multi-Key Press-Release Detector

This block watches a small group of mechanical push buttons. Each button is wired active low and changes with no relation to the system clock. Every raw line first goes through a two-flop synchronizer. A per-key four-state machine then filters contact bounce. All the machines advance together on one shared sample tick, which a prescaler divides down from the clock. A key counts as "hit" only when it has been seen held steadily and then released steadily. At that moment the block emits a single-cycle event that carries the key's index.

Keys that finish in the same clock cycle are not dropped. The lowest index is reported first and the rest follow on the next cycles. For software-style "wait for any key" use, a requester raises a wait line. The block answers with a one-cycle acknowledge and the key index on the first press-release that completes after the line was raised. Earlier completions never satisfy a new wait.

Top module: `keyscan_detect`

## Requirements
- R1: While reset is asserted, and after it is released with all keys up, `evt_valid_o` and `ack_o` stay 0.
- R2: A key line reads 0 when held and 1 when up. A key held steadily and then released steadily produces exactly one `evt_valid_o` pulse. `evt_key_o` equals the key's bit position in `keys_n_i`.
- R3: A key that is held but never released produces no event.
- R4: Every state change needs a settled level. The first sample that differs, plus `STABLE_TICKS` further consecutive matching tick samples, is required. A press shorter than this window produces no event.
- R5: A bouncing line, toggling faster than the tick on both press and release, yields exactly one event per physical press.
- R6: A release that is shorter than the window returns the key to its held state. No event is produced until a full, steady release follows.
- R7: `evt_valid_o` is high for one clock cycle per completed press-release.
- R8: When several keys complete in the same cycle, events are issued on consecutive cycles in ascending key index, and none is lost.
- R9: After `wait_req_i` rises, the first key completion yields a one-cycle `ack_o` with that key's index on `ack_key_o`.
- R10: Completions that occur while `wait_req_i` is low, or before it rose, produce no acknowledge. Only one acknowledge is given per rise of `wait_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| keys_n_i | input | NUM_KEYS | Raw key lines, 0 = held |
| wait_req_i | input | 1 | Wait-for-any-key request level |
| evt_valid_o | output | 1 | One-cycle press-release event |
| evt_key_o | output | IDXW | Key index of the event |
| ack_o | output | 1 | One-cycle wait acknowledge |
| ack_key_o | output | IDXW | Key index that satisfied the wait |

## Verification
The bench builds the block with `TICK_DIV = 8` and `STABLE_TICKS = 3`. With these values a settled level takes only a few dozen clock cycles instead of milliseconds. Short presses, short releases and bounce bursts toggling every three cycles can therefore be placed on either side of the debounce window in a short run. The three default keys are kept, so same-cycle completions of two and of three keys exercise the ascending-order queue.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  typedef enum logic [1:0] {
    KS_IDLE      = 2'd0,
    KS_DOWN_WAIT = 2'd1,
    KS_DOWN      = 2'd2,
    KS_UP_WAIT   = 2'd3
  } ks_state_e;
endpackage

// File: rtl/kscan_sync.sv
module kscan_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= raw_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/kscan_tick.sv
module kscan_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_pulse_chk
      assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/kscan_key.sv
module kscan_key
  import keyscan_pkg::*;
#(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic level_n_i,
  output logic done_o
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  ks_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          held;

  assign held = ~level_n_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    if (tick_i) begin
      unique case (st_q)
        KS_IDLE: begin
          cnt_d = '0;
          if (held) st_d = KS_DOWN_WAIT;
        end
        KS_DOWN_WAIT: begin
          if (!held) begin
            st_d  = KS_IDLE;
            cnt_d = '0;
          end else if (cnt_q == LAST) begin
            st_d  = KS_DOWN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        KS_DOWN: begin
          cnt_d = '0;
          if (!held) st_d = KS_UP_WAIT;
        end
        KS_UP_WAIT: begin
          if (held) begin
            st_d  = KS_DOWN;
            cnt_d = '0;
          end else if (cnt_q == LAST) begin
            st_d   = KS_IDLE;
            cnt_d  = '0;
            done_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = KS_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < STABLE);

  assert_down_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_DOWN && $past(st_q) != KS_DOWN)
      |-> ($past(st_q) == KS_DOWN_WAIT || $past(st_q) == KS_UP_WAIT));

  assert_done_from_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (st_q == KS_IDLE));
endmodule

// File: rtl/keyscan_detect.sv
module keyscan_detect #(
  parameter  int NUM_KEYS     = 3,
  parameter  int TICK_DIV     = 50000,
  parameter  int STABLE_TICKS = 4,
  localparam int IDXW         = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] keys_n_i,
  input  logic                wait_req_i,
  output logic                evt_valid_o,
  output logic [IDXW-1:0]     evt_key_o,
  output logic                ack_o,
  output logic [IDXW-1:0]     ack_key_o
);
  logic [NUM_KEYS-1:0] keys_sync;
  logic [NUM_KEYS-1:0] done;
  logic                tick;

  kscan_sync #(.W(NUM_KEYS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(keys_n_i), .sync_o(keys_sync)
  );

  kscan_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    kscan_key #(.STABLE(STABLE_TICKS)) u_key (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .level_n_i(keys_sync[k]), .done_o(done[k])
    );
  end

  // report queue: lowest index wins, the rest wait in pend_q
  logic [NUM_KEYS-1:0] pend_q, pend_d, req, grant;
  logic [IDXW-1:0]     sel_idx, done_idx;
  logic                evt_d;
  logic [IDXW-1:0]     evt_key_d;

  always_comb begin
    req     = pend_q | done;
    sel_idx = '0;
    grant   = '0;
    for (int k = NUM_KEYS - 1; k >= 0; k--) begin
      if (req[k]) sel_idx = IDXW'(k);
    end
    if (|req) grant[sel_idx] = 1'b1;
    pend_d    = req & ~grant;
    evt_d     = |req;
    evt_key_d = sel_idx;
  end

  // wait handshake: armed on the rise of wait_req_i, fresh completions only
  logic wait_q, armed_q, armed_d, ack_d;

  always_comb begin
    done_idx = '0;
    for (int k = NUM_KEYS - 1; k >= 0; k--) begin
      if (done[k]) done_idx = IDXW'(k);
    end
    ack_d   = armed_q & (|done);
    armed_d = armed_q;
    if (wait_req_i && !wait_q)   armed_d = 1'b1;
    else if (!wait_req_i || ack_d) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      evt_valid_o <= 1'b0;
      evt_key_o   <= '0;
      wait_q      <= 1'b0;
      armed_q     <= 1'b0;
      ack_o       <= 1'b0;
      ack_key_o   <= '0;
    end else begin
      pend_q      <= pend_d;
      evt_valid_o <= evt_d;
      wait_q      <= wait_req_i;
      armed_q     <= armed_d;
      ack_o       <= ack_d;
      if (evt_d) evt_key_o <= evt_key_d;
      if (ack_d) ack_key_o <= done_idx;
    end
  end

  assert_evt_key_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> (int'(evt_key_o) < NUM_KEYS));

  assert_pend_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_q) |-> evt_valid_o);

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  assert_ack_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(wait_req_i, 2));
endmodule

// File: tb/test_keyscan_detect.sv
module test_keyscan_detect;
  localparam int NK = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NK-1:0] keys_n;
  logic          wait_req;
  logic          evt_valid, ack;
  logic [IW-1:0] evt_key, ack_key;

  always #5 clk = ~clk;

  keyscan_detect #(.NUM_KEYS(NK), .TICK_DIV(8), .STABLE_TICKS(3)) i_keyscan_detect (
    .clk(clk), .rst_n(rst_n), .keys_n_i(keys_n), .wait_req_i(wait_req),
    .evt_valid_o(evt_valid), .evt_key_o(evt_key),
    .ack_o(ack), .ack_key_o(ack_key)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int evt_cnt [NK];
  int log_key [64];
  int log_t   [64];
  int log_n = 0;
  int ack_cnt = 0, ack_wide = 0, evt_dbl = 0;
  int ack_last = -1;
  logic prev_evt = 1'b0, prev_ack = 1'b0;
  logic [IW-1:0] prev_key = '0;

  initial for (int i = 0; i < NK; i++) evt_cnt[i] = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (evt_valid) begin
        evt_cnt[evt_key] = evt_cnt[evt_key] + 1;
        if (log_n < 64) begin
          log_key[log_n] = int'(evt_key);
          log_t[log_n]   = cyc;
          log_n          = log_n + 1;
        end
        if (prev_evt && prev_key == evt_key) evt_dbl = evt_dbl + 1;
      end
      if (ack) begin
        ack_cnt  = ack_cnt + 1;
        ack_last = int'(ack_key);
        if (prev_ack) ack_wide = ack_wide + 1;
      end
      prev_evt = evt_valid;
      prev_key = evt_key;
      prev_ack = ack;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tap(input int k, input int down, input int up);
    keys_n[k] = 1'b0;
    step(down);
    keys_n[k] = 1'b1;
    step(up);
  endtask

  task automatic bounce(input int k, input int toggles);
    for (int i = 0; i < toggles; i++) begin
      keys_n[k] = ~keys_n[k];
      step(3);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; keys_n = '1; wait_req = 1'b0;
    step(5);
    check(evt_valid == 1'b0 && ack == 1'b0, "R1 in reset", int'(evt_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    step(100);
    check(log_n == 0 && ack_cnt == 0, "R1 idle after reset", log_n, 0);
  endtask

  task automatic t_single;
    for (int k = 0; k < NK; k++) begin
      int b = evt_cnt[k];
      tap(k, 60, 60);
      check(evt_cnt[k] == b + 1, "R2 one event per tap", evt_cnt[k] - b, 1);
      check(log_key[log_n-1] == k, "R2 key index", log_key[log_n-1], k);
    end
  endtask

  task automatic t_press_only;
    int b = log_n;
    keys_n[1] = 1'b0;
    step(120);
    check(log_n == b, "R3 held key no event", log_n - b, 0);
    keys_n[1] = 1'b1;
    step(60);
    check(log_n == b + 1 && log_key[log_n-1] == 1, "R2 event on release", log_n - b, 1);
  endtask

  task automatic t_short;
    int b = log_n;
    tap(0, 16, 80);
    check(log_n == b, "R4 short press ignored", log_n - b, 0);
  endtask

  task automatic t_bounce;
    int b = evt_cnt[2];
    bounce(2, 13);
    keys_n[2] = 1'b0;
    step(80);
    bounce(2, 13);
    keys_n[2] = 1'b1;
    step(80);
    check(evt_cnt[2] == b + 1, "R5 bounce gives one event", evt_cnt[2] - b, 1);
  endtask

  task automatic t_short_release;
    int b = evt_cnt[1];
    keys_n[1] = 1'b0; step(60);
    keys_n[1] = 1'b1; step(16);
    keys_n[1] = 1'b0; step(60);
    check(evt_cnt[1] == b, "R6 short release ignored", evt_cnt[1] - b, 0);
    keys_n[1] = 1'b1; step(60);
    check(evt_cnt[1] == b + 1, "R6 full release completes", evt_cnt[1] - b, 1);
  endtask

  task automatic t_simul;
    int b = log_n;
    keys_n[0] = 1'b0; keys_n[2] = 1'b0;
    step(60);
    keys_n[0] = 1'b1; keys_n[2] = 1'b1;
    step(60);
    check(log_n == b + 2, "R8 two events kept", log_n - b, 2);
    check(log_key[b] == 0 && log_key[b+1] == 2, "R8 ascending order", log_key[b+1], 2);
    check(log_t[b+1] - log_t[b] == 1, "R8 consecutive cycles", log_t[b+1] - log_t[b], 1);
    b = log_n;
    keys_n = '0; step(60);
    keys_n = '1; step(60);
    check(log_n == b + 3 && log_key[b] == 0 && log_key[b+1] == 1 && log_key[b+2] == 2,
          "R8 three keys ordered", log_n - b, 3);
    check(log_t[b+2] - log_t[b] == 2, "R8 three consecutive", log_t[b+2] - log_t[b], 2);
  endtask

  task automatic t_pulse;
    check(evt_dbl == 0, "R7 single-cycle event", evt_dbl, 0);
  endtask

  task automatic t_wait;
    int a = ack_cnt;
    tap(2, 60, 60);
    check(ack_cnt == a, "R10 no ack while wait low", ack_cnt - a, 0);
    wait_req = 1'b1;
    step(150);
    check(ack_cnt == a, "R10 earlier completion ignored", ack_cnt - a, 0);
    tap(1, 60, 60);
    check(ack_cnt == a + 1, "R9 ack on completion", ack_cnt - a, 1);
    check(ack_last == 1, "R9 ack key index", ack_last, 1);
    tap(0, 60, 60);
    check(ack_cnt == a + 1, "R10 one ack per raise", ack_cnt - a, 1);
    wait_req = 1'b0; step(4);
    wait_req = 1'b1; step(4);
    tap(2, 60, 60);
    check(ack_cnt == a + 2 && ack_last == 2, "R9 re-raise ack key 2", ack_last, 2);
    check(ack_wide == 0, "R9 single-cycle ack", ack_wide, 0);
    wait_req = 1'b0; step(4);
  endtask

  initial begin
    t_reset();
    t_single();
    t_press_only();
    t_short();
    t_bounce();
    t_short_release();
    t_simul();
    t_pulse();
    t_wait();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule